// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the timing for the controller side of an audio serial link. A fast kernel clock is divided by a programmable ratio. The divided clock can be sent to an external converter as a master clock. It also drives a bit-rate strobe and a frame-sync level that marks which channel is active. All logic runs in the kernel clock domain. The bit clock is delivered as a one-cycle enable strobe, not as a derived clock.

Software writes the configuration while the block is stopped. The configuration is an 8-bit divide field, an odd bit, a channel-length select and a master-clock output enable. Software then raises `enable`. The ratio is twice the divide field plus the odd bit. A divide field of zero passes the kernel clock through unchanged. A ratio of three is refused. A divide field larger than the `DIV_MAX` parameter is also refused. A refused setting raises `err_o` and silences every output.

When the master clock is enabled, each bit period spans four master-clock periods. When it is not enabled, each prescaler period is one bit period. The frame-sync level toggles after each channel's worth of bits. A channel holds 16 or 32 bits, so one frame of two channels holds 32 or 64 bits.

Top module: `audio_clkgen`

## Requirements
- R1: The configuration inputs are captured on every clock edge at which `enable` is low, and are held while `enable` is high. Changing them during a run leaves every output unchanged.
- R2: The ratio N is 2*div+odd. With `cfg_mclk_oe`=0, `bclk_en_o` pulses on the last cycle of every N-cycle period. The first pulse comes on the N-th cycle after the edge that samples `enable` high.
- R3: With div=0 the ratio is 1 whatever the odd bit holds. `bclk_en_o` is then high on every active cycle, and `mclk_o` follows the kernel clock when it is enabled.
- R4: div=1 with odd=1 (ratio 3) is illegal. While enabled, `err_o` is 1 and `mclk_o`, `bclk_en_o` and `fsync_o` stay 0.
- R5: A divide field greater than `DIV_MAX` is illegal and behaves as in R4. A field equal to `DIV_MAX` is legal.
- R6: `mclk_o` is 0 whenever `cfg_mclk_oe`=0. When it is enabled and N>1, each period is high for div+odd cycles and then low for div cycles.
- R7: With `cfg_mclk_oe`=1, `bclk_en_o` pulses once every 4*N cycles.
- R8: `fsync_o` starts at 0. It toggles after every 16 `bclk_en_o` pulses when `cfg_ch32`=0, and after every 32 pulses when `cfg_ch32`=1.
- R9: After reset, or after `enable` falls, all outputs are 0 and all counters restart from zero on the next run.
- R10: `err_o` is 0 for every legal setting and whenever `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; the configuration is captured while it is low |
| cfg_div | input | 8 | Divide field |
| cfg_odd | input | 1 | Adds one to the ratio |
| cfg_ch32 | input | 1 | Channel length: 0 gives 16 bits, 1 gives 32 bits |
| cfg_mclk_oe | input | 1 | Master-clock output enable |
| mclk_o | output | 1 | Master clock, held low when not enabled |
| bclk_en_o | output | 1 | One-cycle strobe per bit period |
| fsync_o | output | 1 | Frame-sync level, toggles at channel boundaries |
| err_o | output | 1 | Illegal setting while enabled |

## Verification
The hardest case to reach is a configuration change during a run. A fault here shows up only as a shift in pulse spacing, many cycles later. The driver therefore starts a run with one ratio, rewrites every configuration input partway through, and keeps the queued expectations of the original ratio, so any leak shows as a misplaced strobe or a frame-sync edge. The limit check on the divide field is reached with a second instance that has a small `DIV_MAX`, because the default limit fills the whole field.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int unsigned ACG_DIV_W = 8;
  localparam int unsigned ACG_CNT_W = ACG_DIV_W + 1;

  typedef struct packed {
    logic [ACG_DIV_W-1:0] div;
    logic                 odd;
    logic                 ch32;
    logic                 mclk_oe;
  } acg_cfg_t;

  function automatic logic [ACG_CNT_W-1:0] acg_ratio(input logic [ACG_DIV_W-1:0] d,
                                                     input logic odd);
    if (d == '0) return ACG_CNT_W'(1);
    return {d, 1'b0} + ACG_CNT_W'(odd);
  endfunction

  function automatic logic [ACG_CNT_W-1:0] acg_high_len(input logic [ACG_DIV_W-1:0] d,
                                                        input logic odd);
    return ACG_CNT_W'(d) + ACG_CNT_W'(odd);
  endfunction
endpackage

// File: rtl/acg_prescaler.sv
module acg_prescaler #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] ratio,
  input  logic [CW-1:0] high_len,
  output logic          tick,
  output logic          lvl
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == ratio - CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!active)     cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = active && at_end;
  assign lvl  = active && (cnt_q < high_len);

  // R2: for ratios above one, two prescaler ticks never fall on adjacent cycles
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio > CW'(1)) |=> !tick);
endmodule

// File: rtl/acg_bitdiv.sv
module acg_bitdiv #(
  parameter int unsigned MCLK_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic presc_tick,
  input  logic mclk_mode,
  output logic bit_tick
);
  localparam int unsigned QW = (MCLK_PER_BIT > 1) ? $clog2(MCLK_PER_BIT) : 1;
  localparam logic [QW-1:0] QLAST = QW'(MCLK_PER_BIT - 1);

  logic [QW-1:0] q_q, q_d;
  logic          q_last;

  assign q_last = (q_q == QLAST);

  always_comb begin
    q_d = q_q;
    if (!active || !mclk_mode) q_d = '0;
    else if (presc_tick)       q_d = q_last ? '0 : q_q + QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign bit_tick = mclk_mode ? (presc_tick && q_last) : presc_tick;

  // R7: in master-clock mode each bit strobe coincides with a prescaler tick
  a_r7_bit_on_presc: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> presc_tick);
endmodule

// File: rtl/acg_framer.sv
module acg_framer #(
  parameter int unsigned CH_SHORT = 16,
  parameter int unsigned CH_LONG  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_tick,
  input  logic ch_long,
  output logic fsync
);
  localparam int unsigned BW = $clog2(CH_LONG);
  localparam logic [BW-1:0] LAST_S = BW'(CH_SHORT - 1);
  localparam logic [BW-1:0] LAST_L = BW'(CH_LONG - 1);

  logic [BW-1:0] bc_q, bc_d;
  logic          fs_q, fs_d;
  logic          boundary;

  assign boundary = bit_tick && (bc_q == (ch_long ? LAST_L : LAST_S));

  always_comb begin
    bc_d = bc_q;
    fs_d = fs_q;
    if (!active) begin
      bc_d = '0;
      fs_d = 1'b0;
    end else if (bit_tick) begin
      bc_d = boundary ? '0 : bc_q + BW'(1);
      if (boundary) fs_d = ~fs_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q <= '0;
      fs_q <= 1'b0;
    end else begin
      bc_q <= bc_d;
      fs_q <= fs_d;
    end
  end

  assign fsync = fs_q;

  // R8: frame sync moves only after a bit strobe, or when the run stops
  a_r8_fsync_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fs_q) && $past(active)) |-> $past(bit_tick));
  // R9: stopping the run clears the frame sync
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !fs_q);
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int unsigned DIV_MAX      = 255,
  parameter int unsigned MCLK_PER_BIT = 4,
  parameter int unsigned CH_SHORT     = 16,
  parameter int unsigned CH_LONG      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [ACG_DIV_W-1:0] cfg_div,
  input  logic                 cfg_odd,
  input  logic                 cfg_ch32,
  input  logic                 cfg_mclk_oe,
  output logic                 mclk_o,
  output logic                 bclk_en_o,
  output logic                 fsync_o,
  output logic                 err_o
);
  localparam logic [ACG_CNT_W-1:0] LIMIT = ACG_CNT_W'(DIV_MAX);

  acg_cfg_t cfg_q, cfg_d;
  logic     run_q, run_d;
  logic     illegal, active, bypass;
  logic [ACG_CNT_W-1:0] ratio, high_len;
  logic     presc_tick, presc_lvl, bit_tick;

  always_comb begin
    cfg_d = cfg_q;
    if (!enable) cfg_d = '{div: cfg_div, odd: cfg_odd, ch32: cfg_ch32, mclk_oe: cfg_mclk_oe};
    run_d = enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      run_q <= run_d;
    end
  end

  assign illegal  = ((cfg_q.div == ACG_DIV_W'(1)) && cfg_q.odd) ||
                    (ACG_CNT_W'(cfg_q.div) > LIMIT);
  assign active   = run_q && !illegal;
  assign bypass   = (cfg_q.div == '0);
  assign ratio    = acg_ratio(cfg_q.div, cfg_q.odd);
  assign high_len = acg_high_len(cfg_q.div, cfg_q.odd);

  acg_prescaler #(.CW(ACG_CNT_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .active(active), .ratio(ratio),
    .high_len(high_len), .tick(presc_tick), .lvl(presc_lvl)
  );

  acg_bitdiv #(.MCLK_PER_BIT(MCLK_PER_BIT)) u_bitdiv (
    .clk(clk), .rst_n(rst_n), .active(active), .presc_tick(presc_tick),
    .mclk_mode(cfg_q.mclk_oe), .bit_tick(bit_tick)
  );

  acg_framer #(.CH_SHORT(CH_SHORT), .CH_LONG(CH_LONG)) u_framer (
    .clk(clk), .rst_n(rst_n), .active(active), .bit_tick(bit_tick),
    .ch_long(cfg_q.ch32), .fsync(fsync_o)
  );

  assign mclk_o    = active && cfg_q.mclk_oe && (bypass ? clk : presc_lvl);
  assign bclk_en_o = bit_tick;
  assign err_o     = run_q && illegal;

  // R1: the captured configuration does not move during a run
  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(cfg_q));
  // R4: an illegal setting silences the strobe and frame sync
  a_r4_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!bclk_en_o && !fsync_o));
  // R10: no error is reported while stopped
  a_r10_no_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !err_o);
endmodule

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst_n;
  logic enable;
  logic [7:0] cfg_div;
  logic cfg_odd, cfg_ch32, cfg_mclk_oe;
  logic mclk_o, bclk_en_o, fsync_o, err_o;
  logic mclk_l, bclk_l, fsync_l, err_l;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic mclk;
    logic bclk;
    logic fs;
    logic err;
    int   req;
  } exp_t;
  exp_t sb_q[$];

  always #(HALF) clk = ~clk;

  audio_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div), .cfg_odd(cfg_odd),
    .cfg_ch32(cfg_ch32), .cfg_mclk_oe(cfg_mclk_oe), .mclk_o(mclk_o),
    .bclk_en_o(bclk_en_o), .fsync_o(fsync_o), .err_o(err_o)
  );

  audio_clkgen #(.DIV_MAX(100)) u_dut_lim (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div), .cfg_odd(cfg_odd),
    .cfg_ch32(cfg_ch32), .cfg_mclk_oe(cfg_mclk_oe), .mclk_o(mclk_l),
    .bclk_en_o(bclk_l), .fsync_o(fsync_l), .err_o(err_l)
  );

  task automatic check(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // monitor: pops one expectation per cycle, sampled 1 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, "mclk_o",    int'(mclk_o),    int'(e.mclk));
        check(e.req, "bclk_en_o", int'(bclk_en_o), int'(e.bclk));
        check(e.req, "fsync_o",   int'(fsync_o),   int'(e.fs));
        check(e.req, "err_o",     int'(err_o),     int'(e.err));
      end
    end
  end

  task automatic load_cfg(input int d, input bit o, input bit c32, input bit oe);
    @(negedge clk);
    enable = 1'b0;
    cfg_div = 8'(d); cfg_odd = o; cfg_ch32 = c32; cfg_mclk_oe = oe;
    repeat (2) @(negedge clk);
  endtask

  // driver: starts a run and queues the expected outputs, derived from the requirements
  task automatic run_legal(input int d, input bit o, input bit c32, input bit oe,
                           input int ncyc, input int req);
    int n, h, p, ch;
    load_cfg(d, o, c32, oe);
    n  = (d == 0) ? 1 : 2 * d + int'(o);
    h  = d + int'(o);
    p  = oe ? 4 * n : n;
    ch = c32 ? 32 : 16;
    enable = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      exp_t e;
      e.bclk = ((k % p) == p - 1);
      e.fs   = ((k / p) / ch) % 2 == 1;
      e.mclk = oe ? ((n == 1) ? 1'b1 : ((k % n) < h)) : 1'b0;
      e.err  = 1'b0;
      e.req  = req;
      sb_q.push_back(e);
    end
  endtask

  task automatic drain;
    while (sb_q.size() != 0) @(negedge clk);
    enable = 1'b0;
  endtask

  initial begin
    fork
      begin
        #(HALF * 2 * 150000);
        fails++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    rst_n = 1'b0; enable = 1'b0;
    cfg_div = '0; cfg_odd = 1'b0; cfg_ch32 = 1'b0; cfg_mclk_oe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R9 reset state
    check(9, "reset mclk_o",  int'(mclk_o), 0);
    check(9, "reset bclk_en", int'(bclk_en_o), 0);
    check(9, "reset fsync_o", int'(fsync_o), 0);
    check(10, "reset err_o",  int'(err_o), 0);

    // R2 and R8: ratio 5, short channels, no master clock
    run_legal(2, 1'b1, 1'b0, 1'b0, 200, 2); drain();
    // R9: rerun after stop, counters restart; R6 even ratio with master clock, duty 50%
    run_legal(3, 1'b0, 1'b0, 1'b1, 120, 6); drain();
    // R7 and R8: ratio 6 with master clock, long channels
    run_legal(3, 1'b0, 1'b1, 1'b1, 1600, 7); drain();
    // R3: bypass with the odd bit set, master clock on
    run_legal(0, 1'b1, 1'b0, 1'b1, 100, 3); drain();
    // R3: bypass without master clock
    run_legal(0, 1'b0, 1'b1, 1'b0, 80, 3); drain();
    // R6: odd ratio 7, high phase one cycle longer
    run_legal(3, 1'b1, 1'b0, 1'b1, 90, 6); drain();
    // R2: smallest even ratio 2, and the largest ratio 511
    run_legal(1, 1'b0, 1'b0, 1'b0, 70, 2); drain();
    run_legal(255, 1'b1, 1'b0, 1'b0, 1100, 2); drain();

    // R1: rewrite the configuration during a ratio-7 run; expectations stay
    run_legal(3, 1'b1, 1'b0, 1'b0, 300, 1);
    repeat (60) @(negedge clk);
    cfg_div = 8'd10; cfg_odd = 1'b0; cfg_ch32 = 1'b1; cfg_mclk_oe = 1'b1;
    drain();

    // R4: ratio three is refused
    load_cfg(1, 1'b1, 1'b0, 1'b1);
    enable = 1'b1;
    for (int k = 0; k < 30; k++) begin
      exp_t e;
      e.mclk = 1'b0; e.bclk = 1'b0; e.fs = 1'b0; e.err = 1'b1; e.req = 4;
      sb_q.push_back(e);
    end
    drain();
    @(posedge clk); #1;
    check(10, "err_o after stop", int'(err_o), 0);

    // R5: limit of the second instance is 100
    load_cfg(101, 1'b0, 1'b0, 1'b1);
    enable = 1'b1;
    @(posedge clk); #1;
    check(5, "lim err_o div=101", int'(err_l), 1);
    check(5, "lim mclk_o div=101", int'(mclk_l), 0);
    check(10, "main err_o div=101", int'(err_o), 0);
    repeat (210) begin
      @(posedge clk); #1;
      check(5, "lim bclk_en div=101", int'(bclk_l), 0);
    end
    load_cfg(100, 1'b0, 1'b0, 1'b0);
    enable = 1'b1;
    @(posedge clk); #1;
    check(5, "lim err_o div=100", int'(err_l), 0);
    repeat (199) @(posedge clk);
    #1;
    check(5, "lim bclk_en at cycle 200", int'(bclk_l), 1);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(9, "mclk_o after stop", int'(mclk_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule